// File: doc/BRIEF.md
# Area-based external bus wait controller

This block sits between a CPU-side request port and the external memory bus. Each request carries a 29-bit physical address. The block decodes the address into one of six external memory areas, drives a chip select for that area, and produces a read or write strobe whose length is set by software for each area. An external hold input can stretch the strobe. When the CPU finishes the access, it receives a one-cycle acknowledge. If the address decodes to an area that has no external memory, the block does not touch the bus and returns an acknowledge with an error flag.

Between accesses the controller adds a single idle cycle on its own when two accesses could fight over the data bus. This happens when the new access goes to a different area from the last one, or when a write follows a read of the same area. Each area also has a bus-width setting, which the block only reports. Area 0 takes its width from a strap input. The other areas take it from their registers.

The sequencer is a state machine with six states:

- IDLE waits for a request. On a request it moves to one of three states:
  - FAULT, when the area is not external.
  - TURN, when an idle cycle is needed.
  - SETUP, otherwise.
- TURN always moves to SETUP.
- SETUP always moves to STROBE.
- STROBE stays put while programmed wait cycles remain. In its last programmed cycle it also stays put while the hold input is high. Otherwise it moves to HOLD.
- HOLD and FAULT both return to IDLE.

Top module: `ext_bus_wait_ctrl`

## Requirements
- R1: Address bits [28:26] select the area, and bit i of `area_sel` is the chip select of area i. At most one select is high at a time, and it stays constant for the whole access. `bus_offset` carries address bits [25:0] while a select is high.
- R2: Areas 1 and 7 are not external. A request to them raises no select or strobe. In the first cycle after acceptance, `ack` and `ack_err` are both high for one cycle. Such a request does not change the record of the last access.
- R3: `cfg_wait` holds the wait count minus one. The strobe lasts that count in cycles when the hold input is low. Values above the area's limit are clamped to the limit: 10 cycles for areas 0, 2, 3 and 4, and 38 cycles for areas 5 and 6.
- R4: `ext_hold` is sampled only in the last programmed strobe cycle and in the cycles after it. Each sampled high level adds one strobe cycle. A high level during earlier strobe cycles has no effect.
- R5: When an external access targets a different area from the previous external access, one cycle with no select and no strobe comes before its select.
- R6: When a write follows a read of the same area, one such idle cycle is inserted. A read after a write, or two accesses of the same direction to the same area, get no idle cycle.
- R7: The select rises one cycle before the strobe and falls one cycle after it. `ack` is high for exactly that last select cycle. The cycle after `ack` is idle.
- R8: After reset, all outputs are low and every area uses its maximum wait count. The first access gets no idle cycle.
- R9: While a select is high, `bus_width` shows that area's width. For area 0 this is `strap_width0`. For any other area it is the last `cfg_width` written to it, or 0 after reset.
- R10: `rd_strobe` is used when `req_write` is 0 and `wr_strobe` when it is 1. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, held until `ack` |
| req_addr | input | 29 | Physical address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| cfg_we | input | 1 | Configuration write enable |
| cfg_area | input | 3 | Area whose configuration is written |
| cfg_wait | input | 6 | Wait count minus one |
| cfg_width | input | 2 | Bus width code for the area |
| strap_width0 | input | 2 | Bus width code of area 0 |
| ext_hold | input | 1 | External hold (wait) request, active high |
| area_sel | output | 8 | One-hot per-area chip select |
| rd_strobe | output | 1 | Read strobe |
| wr_strobe | output | 1 | Write strobe |
| ack | output | 1 | One-cycle completion pulse |
| ack_err | output | 1 | Completion with error (non-external area) |
| bus_offset | output | 26 | Offset within the area |
| bus_width | output | 2 | Width code of the selected area |

## Verification
The assertions assume that the CPU holds `req_valid`, `req_addr` and `req_write` steady from the request until `ack`, and drops `req_valid` in the `ack` cycle. The bench meets this by driving every request from a single task that releases it at the `ack` sample. The hold input is assumed to fall eventually. The bench keeps every hold run short and fixed by the scenario. Configuration writes are assumed to happen outside accesses, and the bench only issues them between accesses.

// File: rtl/ebw_pkg.sv
package ebw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_FAULT
    } seq_state_e;

    // Default geometry shared by the block and its checker.
    localparam int DEF_AREA_W   = 3;
    localparam int DEF_OFFSET_W = 26;
    localparam int DEF_WAIT_W   = 6;
    localparam int DEF_WIDTH_W  = 2;

endpackage

// File: rtl/ebw_area_decode.sv
module ebw_area_decode #(
    parameter int AREA_W   = 3,
    parameter int OFFSET_W = 26,
    parameter int ADDR_W   = AREA_W + OFFSET_W,
    parameter int NUM_AREAS = 1 << AREA_W,
    parameter logic [NUM_AREAS-1:0] EXT_MASK = '1
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [AREA_W-1:0]   area,
    output logic [OFFSET_W-1:0] offset,
    output logic                is_ext
);

    always_comb begin
        area   = addr[OFFSET_W +: AREA_W];
        offset = addr[OFFSET_W-1:0];
        is_ext = EXT_MASK[area];
    end

endmodule

// File: rtl/ebw_cfg_regs.sv
module ebw_cfg_regs #(
    parameter int AREA_W     = 3,
    parameter int WAIT_W     = 6,
    parameter int WIDTH_W    = 2,
    parameter int NUM_AREAS  = 1 << AREA_W,
    parameter int SHORT_MAX  = 10,
    parameter int LONG_MAX   = 38,
    parameter int STRAP_AREA = 0,
    parameter logic [NUM_AREAS-1:0] EXT_MASK  = '1,
    parameter logic [NUM_AREAS-1:0] LONG_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [AREA_W-1:0]  cfg_area,
    input  logic [WAIT_W-1:0]  cfg_wait,
    input  logic [WIDTH_W-1:0] cfg_width,
    input  logic [WIDTH_W-1:0] strap_width,
    input  logic [AREA_W-1:0]  rd_area,
    output logic [WAIT_W-1:0]  rd_wait,
    output logic [WIDTH_W-1:0] rd_width
);

    logic [NUM_AREAS*WAIT_W-1:0]  wait_flat;
    logic [NUM_AREAS*WIDTH_W-1:0] width_flat;

    for (genvar i = 0; i < NUM_AREAS; i++) begin : g_area
        if (EXT_MASK[i]) begin : g_ext
            localparam int LIM = (LONG_MASK[i] ? LONG_MAX : SHORT_MAX) - 1;
            localparam logic [WAIT_W-1:0] LIM_V = WAIT_W'(LIM);

            logic              hit;
            logic [WAIT_W-1:0] wait_q;

            assign hit = cfg_we && (cfg_area == AREA_W'(i));

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    wait_q <= LIM_V;
                end else if (hit) begin
                    wait_q <= (cfg_wait > LIM_V) ? LIM_V : cfg_wait;
                end
            end
            assign wait_flat[i*WAIT_W +: WAIT_W] = wait_q;

            if (i == STRAP_AREA) begin : g_strap
                assign width_flat[i*WIDTH_W +: WIDTH_W] = strap_width;
            end else begin : g_reg
                logic [WIDTH_W-1:0] width_q;
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        width_q <= '0;
                    end else if (hit) begin
                        width_q <= cfg_width;
                    end
                end
                assign width_flat[i*WIDTH_W +: WIDTH_W] = width_q;
            end
        end else begin : g_none
            assign wait_flat[i*WAIT_W +: WAIT_W]    = '0;
            assign width_flat[i*WIDTH_W +: WIDTH_W] = '0;
        end
    end

    always_comb begin
        rd_wait  = '0;
        rd_width = '0;
        for (int j = 0; j < NUM_AREAS; j++) begin
            if (rd_area == AREA_W'(j)) begin
                rd_wait  = wait_flat[j*WAIT_W +: WAIT_W];
                rd_width = width_flat[j*WIDTH_W +: WIDTH_W];
            end
        end
    end

endmodule

// File: rtl/ebw_seq.sv
module ebw_seq
    import ebw_pkg::*;
#(
    parameter int AREA_W = 3,
    parameter int WAIT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AREA_W-1:0] req_area,
    input  logic              req_ext,
    input  logic [WAIT_W-1:0] wait_field,
    input  logic              ext_hold,
    output logic              accept,
    output logic [AREA_W-1:0] cur_area,
    output logic              cs_on,
    output logic              rd_on,
    output logic              wr_on,
    output logic              ack_on,
    output logic              err_on
);

    seq_state_e state_q, state_d;

    logic [WAIT_W-1:0] cnt_q;
    logic [AREA_W-1:0] area_q;
    logic              write_q;
    logic              last_valid_q;
    logic [AREA_W-1:0] last_area_q;
    logic              last_read_q;
    logic              need_turn;

    // Bus conflict guard: area change, or write right after a read.
    always_comb begin
        need_turn = last_valid_q &&
                    ((last_area_q != req_area) || (last_read_q && req_write));
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (!req_ext) begin
                        state_d = ST_FAULT;
                    end else if (need_turn) begin
                        state_d = ST_TURN;
                    end else begin
                        state_d = ST_SETUP;
                    end
                end
            end
            ST_TURN:   state_d = ST_SETUP;
            ST_SETUP:  state_d = ST_STROBE;
            ST_STROBE: begin
                if ((cnt_q == '0) && !ext_hold) begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD:   state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Access context, wait counter and last-access record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            area_q       <= '0;
            write_q      <= 1'b0;
            last_valid_q <= 1'b0;
            last_area_q  <= '0;
            last_read_q  <= 1'b1;
        end else begin
            if (accept && req_ext) begin
                area_q  <= req_area;
                write_q <= req_write;
            end
            if (state_q == ST_SETUP) begin
                cnt_q <= wait_field;
            end else if ((state_q == ST_STROBE) && (cnt_q != '0)) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (state_q == ST_HOLD) begin
                last_valid_q <= 1'b1;
                last_area_q  <= area_q;
                last_read_q  <= !write_q;
            end
        end
    end

    // Outputs decoded from the registered state.
    always_comb begin
        cs_on  = 1'b0;
        rd_on  = 1'b0;
        wr_on  = 1'b0;
        ack_on = 1'b0;
        err_on = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_TURN: ;
            ST_SETUP:  cs_on = 1'b1;
            ST_STROBE: begin
                cs_on = 1'b1;
                rd_on = !write_q;
                wr_on = write_q;
            end
            ST_HOLD: begin
                cs_on  = 1'b1;
                ack_on = 1'b1;
            end
            ST_FAULT: begin
                ack_on = 1'b1;
                err_on = 1'b1;
            end
            default: ;
        endcase
    end

    assign cur_area = area_q;

endmodule

// File: rtl/ext_bus_wait_ctrl.sv
module ext_bus_wait_ctrl
    import ebw_pkg::*;
#(
    parameter int AREA_W    = DEF_AREA_W,
    parameter int OFFSET_W  = DEF_OFFSET_W,
    parameter int WAIT_W    = DEF_WAIT_W,
    parameter int WIDTH_W   = DEF_WIDTH_W,
    parameter int ADDR_W    = AREA_W + OFFSET_W,
    parameter int NUM_AREAS = 1 << AREA_W,
    parameter int SHORT_MAX = 10,
    parameter int LONG_MAX  = 38,
    parameter logic [NUM_AREAS-1:0] EXT_MASK  = 8'b0111_1101,
    parameter logic [NUM_AREAS-1:0] LONG_MASK = 8'b0110_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_write,
    input  logic                 cfg_we,
    input  logic [AREA_W-1:0]    cfg_area,
    input  logic [WAIT_W-1:0]    cfg_wait,
    input  logic [WIDTH_W-1:0]   cfg_width,
    input  logic [WIDTH_W-1:0]   strap_width0,
    input  logic                 ext_hold,
    output logic [NUM_AREAS-1:0] area_sel,
    output logic                 rd_strobe,
    output logic                 wr_strobe,
    output logic                 ack,
    output logic                 ack_err,
    output logic [OFFSET_W-1:0]  bus_offset,
    output logic [WIDTH_W-1:0]   bus_width
);

    logic [AREA_W-1:0]   dec_area;
    logic [OFFSET_W-1:0] dec_offset;
    logic                dec_ext;
    logic                accept;
    logic [AREA_W-1:0]   cur_area;
    logic [WAIT_W-1:0]   cur_wait;
    logic [WIDTH_W-1:0]  cur_width;
    logic                cs_on;
    logic [OFFSET_W-1:0] offset_q;

    ebw_area_decode #(
        .AREA_W   (AREA_W),
        .OFFSET_W (OFFSET_W),
        .ADDR_W   (ADDR_W),
        .NUM_AREAS(NUM_AREAS),
        .EXT_MASK (EXT_MASK)
    ) u_dec (
        .addr  (req_addr),
        .area  (dec_area),
        .offset(dec_offset),
        .is_ext(dec_ext)
    );

    ebw_cfg_regs #(
        .AREA_W    (AREA_W),
        .WAIT_W    (WAIT_W),
        .WIDTH_W   (WIDTH_W),
        .NUM_AREAS (NUM_AREAS),
        .SHORT_MAX (SHORT_MAX),
        .LONG_MAX  (LONG_MAX),
        .STRAP_AREA(0),
        .EXT_MASK  (EXT_MASK),
        .LONG_MASK (LONG_MASK)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_area   (cfg_area),
        .cfg_wait   (cfg_wait),
        .cfg_width  (cfg_width),
        .strap_width(strap_width0),
        .rd_area    (cur_area),
        .rd_wait    (cur_wait),
        .rd_width   (cur_width)
    );

    ebw_seq #(
        .AREA_W(AREA_W),
        .WAIT_W(WAIT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_area  (dec_area),
        .req_ext   (dec_ext),
        .wait_field(cur_wait),
        .ext_hold  (ext_hold),
        .accept    (accept),
        .cur_area  (cur_area),
        .cs_on     (cs_on),
        .rd_on     (rd_strobe),
        .wr_on     (wr_strobe),
        .ack_on    (ack),
        .err_on    (ack_err)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset_q <= '0;
        end else if (accept && dec_ext) begin
            offset_q <= dec_offset;
        end
    end

    for (genvar i = 0; i < NUM_AREAS; i++) begin : g_sel
        assign area_sel[i] = cs_on && (cur_area == AREA_W'(i));
    end

    assign bus_offset = offset_q;
    assign bus_width  = cs_on ? cur_width : '0;

endmodule

// File: rtl/ebw_checker.sv
module ebw_checker #(
    parameter int NUM_AREAS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_AREAS-1:0] area_sel,
    input logic                 rd_strobe,
    input logic                 wr_strobe,
    input logic                 ack,
    input logic                 ack_err
);

    logic strobe;
    logic any_sel;
    assign strobe  = rd_strobe | wr_strobe;
    assign any_sel = |area_sel;

    assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(area_sel));

    assert_sel_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (any_sel && $past(any_sel)) |-> $stable(area_sel));

    assert_err_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err |-> (ack && !any_sel && !strobe));

    assert_strobe_in_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> any_sel);

    assert_sel_leads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe) |-> $past(any_sel));

    assert_sel_trails_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe) |-> (any_sel && ack));

    assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    assert_idle_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !any_sel);

    assert_no_dual_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strobe && wr_strobe));

endmodule

bind ext_bus_wait_ctrl ebw_checker #(.NUM_AREAS(NUM_AREAS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .area_sel (area_sel),
    .rd_strobe(rd_strobe),
    .wr_strobe(wr_strobe),
    .ack      (ack),
    .ack_err  (ack_err)
);

// File: tb/sim_ext_bus_wait_ctrl.sv
module sim_ext_bus_wait_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [28:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_area = '0;
    logic [5:0]  cfg_wait = '0;
    logic [1:0]  cfg_width = '0;
    logic [1:0]  strap_width0 = 2'b10;
    logic        ext_hold = 1'b0;
    logic [7:0]  area_sel;
    logic        rd_strobe, wr_strobe, ack, ack_err;
    logic [25:0] bus_offset;
    logic [1:0]  bus_width;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Behavioural model state.
    int wait_n[8];
    int width_m[8];
    int last_area = -1;
    bit last_read = 1'b1;
    int off_seed = 26'h0012345;

    always #4 clk = ~clk;

    ext_bus_wait_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .cfg_we(cfg_we), .cfg_area(cfg_area),
        .cfg_wait(cfg_wait), .cfg_width(cfg_width), .strap_width0(strap_width0),
        .ext_hold(ext_hold), .area_sel(area_sel), .rd_strobe(rd_strobe),
        .wr_strobe(wr_strobe), .ack(ack), .ack_err(ack_err),
        .bus_offset(bus_offset), .bus_width(bus_width)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] bus_vec();
        return {52'd0, area_sel, rd_strobe, wr_strobe, ack, ack_err};
    endfunction

    function automatic logic [63:0] exp_vec(int a, bit cs, bit rd, bit wr, bit ak, bit er);
        logic [7:0] s;
        s = cs ? 8'(1 << a) : 8'd0;
        return {52'd0, s, rd, wr, ak, er};
    endfunction

    task automatic cfg_write(int a, int f, int w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_area = 3'(a); cfg_wait = 6'(f); cfg_width = 2'(w);
        @(negedge clk);
        cfg_we = 1'b0;
        if (a != 1 && a != 7) begin
            int lim;
            lim = (a == 5 || a == 6) ? 37 : 9;
            wait_n[a] = ((f > lim) ? lim : f) + 1;
            if (a != 0) width_m[a] = w;
        end
    endtask

    task automatic access(int a, bit wr, int extra, bit noise, string tag);
        bit ext;
        bit turn;
        int n;
        logic [25:0] off;
        ext  = (a != 1) && (a != 7);
        turn = ext && (last_area >= 0) && ((last_area != a) || (last_read && wr));
        n    = wait_n[a];
        off_seed = (off_seed * 5 + 26'h0777) & 26'h3FF_FFFF;
        off  = 26'(off_seed);
        @(negedge clk);
        req_valid = 1'b1; req_addr = {3'(a), off}; req_write = wr;
        if (!ext) begin
            @(negedge clk);
            chk({"R2 fault ack ", tag}, bus_vec(), exp_vec(a, 0, 0, 0, 1, 1));
            req_valid = 1'b0;
            @(negedge clk);
            chk({"R2 after fault ", tag}, bus_vec(), exp_vec(a, 0, 0, 0, 0, 0));
            return;
        end
        if (turn) begin
            @(negedge clk);
            chk({"R5/R6 idle cycle ", tag}, bus_vec(), exp_vec(a, 0, 0, 0, 0, 0));
        end
        @(negedge clk);
        chk({"R7 setup ", tag}, bus_vec(), exp_vec(a, 1, 0, 0, 0, 0));
        chk({"R1 offset ", tag}, 64'(bus_offset), 64'(off));
        chk({"R9 width ", tag}, 64'(bus_width), 64'(width_m[a]));
        for (int k = 1; k <= n + extra; k++) begin
            @(negedge clk);
            chk({"R3/R4/R10 strobe ", tag}, bus_vec(), exp_vec(a, 1, !wr, wr, 0, 0));
            ext_hold = (noise && k < n) || (k >= n && k < n + extra);
        end
        @(negedge clk);
        ext_hold = 1'b0;
        chk({"R7 hold/ack ", tag}, bus_vec(), exp_vec(a, 1, 0, 0, 1, 0));
        req_valid = 1'b0;
        @(negedge clk);
        chk({"R7 idle after ack ", tag}, bus_vec(), exp_vec(a, 0, 0, 0, 0, 0));
        last_area = a;
        last_read = !wr;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            wait_n[i]  = (i == 5 || i == 6) ? 38 : 10;
            width_m[i] = 0;
        end
        width_m[0] = 2;
        repeat (3) @(negedge clk);
        chk("R8 reset outputs", bus_vec(), 64'd0);
        chk("R8 reset width", 64'(bus_width), 64'd0);
        rst_n = 1'b1;

        access(2, 0, 0, 0, "R8 first access no idle, default 10");
        access(2, 0, 0, 0, "R6 read after read");
        access(2, 1, 0, 0, "R6 write after read");
        access(2, 1, 0, 0, "R6 write after write");
        access(2, 0, 0, 0, "R6 read after write");
        access(5, 0, 0, 0, "R5 area change, default 38");
        cfg_write(5, 50, 1);
        access(5, 0, 0, 0, "R3 clamp long area");
        cfg_write(6, 0, 3);
        access(6, 1, 3, 0, "R4 hold extends one-cycle strobe");
        cfg_write(0, 2, 1);
        access(0, 0, 0, 1, "R4 early hold ignored, R9 strap");
        access(0, 0, 2, 1, "R4 hold extends");
        access(1, 0, 0, 0, "R2 area 1");
        access(7, 1, 0, 0, "R2 area 7");
        access(0, 0, 0, 0, "R2 fault leaves last access");
        cfg_write(3, 20, 1);
        access(3, 1, 0, 0, "R3 clamp short area, R9 width");
        cfg_write(4, 4, 2);
        access(4, 0, 1, 1, "R10 read area 4");
        access(4, 1, 0, 0, "R10 write area 4");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule